// File: doc/BRIEF.md
# Serial Flash Page Rewrite Sequencer

This block is the host-side master of a two-wire in-circuit programming link: a serial clock line and a data line. It rewrites one whole erase page of a target microcontroller's flash. A start pulse carries a 22-bit page address. The block then drives every frame the target needs to do the job. It points the target's table address at the page, arms and fires the erase, and waits out the erase hold. It then refills the target's write buffer burst by burst, waits out a programming hold after each burst, and finally clears the target's write enable.

Each frame is a 4-bit command code followed by a 16-bit payload, both shifted least-significant bit first. The replacement data comes from a local buffer. The buffer is read one 16-bit word at a time through a request strobe, and the word must be valid in the same cycle as the strobe. Entry-key generation, read-back and verification belong to other blocks. The data line is only ever driven by this block.

Top module: `page_rewrite_seq`

## Requirements
- R1: After reset `pgc`, `pgd`, `busy`, `done`, `err` and `rd_req` are all low, and `pgc` stays low whenever the block is idle.
- R2: Every frame has 20 serial clocks: the 4 command bits, then the 16 payload bits, each least-significant bit first. `pgd` changes only in the cycle where `pgc` rises and is held while `pgc` is high. Each ordinary high phase and each low phase lasts HALF_DIV system clocks.
- R3: The pointer load is six frames with command 0000 and these payloads: 0x0E00 ORed with address bits 21:16, then 0x6EF8, then 0x0E00 ORed with bits 15:8, then 0x6EF7, then 0x0E00 ORed with bits 7:0, then 0x6EF6. This load is sent once with the page address before the erase.
- R4: The erase is three command-0000 frames with payloads 0x84A6, 0x88A6 and 0x82A6. They are followed by a NOP frame (command 0000, payload 0x0000) whose fourth clock stays high for ERASE_HOLD system clocks with `pgd` low.
- R5: Each burst b (counting from 0) reloads the pointer as in R3, with address page + b×2×WORDS. It then sends WORDS−1 frames with command 1101 and one final frame with command 1111, each carrying the next buffer word as payload.
- R6: Each burst is followed by a NOP frame whose fourth clock stays high for PROG_HOLD system clocks with `pgd` low.
- R7: After BURSTS bursts, one command-0000 frame with payload 0x94A6 ends the sequence. A full page is 6+3+1+BURSTS×(6+WORDS+1)+1 frames (635 with default sizes).
- R8: `rd_req` pulses for one cycle per data frame, BURSTS×WORDS times per page. `rd_data` is taken in the cycle of the pulse, and `rd_req` is high only while `busy` is high.
- R9: `busy` is high from the cycle after an accepted start. `done` pulses for exactly one cycle, after the final serial clock falls, in the same cycle that `busy` returns low.
- R10: A start whose address has any of its low log2(page bytes) bits set (10 bits by default) sets `err`. No frame and no `rd_req` follow, and `busy` stays low. The next accepted start clears `err`.
- R11: A start pulse while `busy` is high is ignored. The running page and its frames are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to rewrite a page |
| page_addr | input | 22 | Page byte address, sampled with `start` |
| rd_req | output | 1 | Strobe consuming one buffer word |
| rd_data | input | 16 | Buffer word, valid in the cycle of `rd_req` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected as misaligned |
| pgc | output | 1 | Serial programming clock to the target |
| pgd | output | 1 | Serial programming data to the target |

## Verification
The serial results do not depend on latency. The bench decodes each bit at the falling edge of `pgc`, which is where the target samples. It measures every high phase in system clocks, so frame contents and hold lengths are checked whatever the gap between frames. `busy` and `err` are due one register after the edge that samples `start`, so they are checked at the first falling system clock edge after the start pulse. `rd_data` is consumed at the same edge that sees `rd_req`, so the bench's buffer index moves only one sample later. `done` is checked in its own cycle against `busy` being low, and one cycle later against `done` being low again.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PTR,
        PH_ERASE,
        PH_EHOLD,
        PH_BPTR,
        PH_WRITE,
        PH_PHOLD,
        PH_WDIS,
        PH_DRAIN
    } phase_e;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [15:0] payload;
        logic        hold_erase;
        logic        hold_prog;
    } frame_t;

    localparam logic [3:0]  CMD_CORE     = 4'b0000;
    localparam logic [3:0]  CMD_WR_INC   = 4'b1101;
    localparam logic [3:0]  CMD_WR_START = 4'b1111;

    localparam logic [7:0]  OP_LOAD_LIT  = 8'h0E;
    localparam logic [15:0] OP_MOV_UPPER = 16'h6EF8;
    localparam logic [15:0] OP_MOV_HIGH  = 16'h6EF7;
    localparam logic [15:0] OP_MOV_LOW   = 16'h6EF6;
    localparam logic [15:0] OP_SET_WREN  = 16'h84A6;
    localparam logic [15:0] OP_SET_FREE  = 16'h88A6;
    localparam logic [15:0] OP_SET_WR    = 16'h82A6;
    localparam logic [15:0] OP_CLR_WREN  = 16'h94A6;
    localparam logic [15:0] OP_NOP       = 16'h0000;

endpackage

// File: rtl/prs_frame_gen.sv
module prs_frame_gen
    import prs_pkg::*;
#(
    parameter int WORDS  = 32,
    parameter int BURSTS = 16,
    parameter int IDX_W  = 5,
    parameter int BW     = 4
) (
    input  phase_e            ph,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BW-1:0]     burst,
    input  logic [21:0]       page,
    input  logic [15:0]       wdata,
    output frame_t            frm
);
    localparam int OFF_W = $clog2(2 * WORDS);

    logic [21:0] ptr;

    always_comb begin
        if (ph == PH_BPTR) begin
            ptr = page + (22'(burst) << OFF_W);
        end else begin
            ptr = page;
        end
    end

    always_comb begin
        frm = '{cmd: CMD_CORE, payload: OP_NOP, hold_erase: 1'b0, hold_prog: 1'b0};
        case (ph)
            PH_PTR, PH_BPTR: begin
                case (idx)
                    IDX_W'(0): frm.payload = {OP_LOAD_LIT, 2'b00, ptr[21:16]};
                    IDX_W'(1): frm.payload = OP_MOV_UPPER;
                    IDX_W'(2): frm.payload = {OP_LOAD_LIT, ptr[15:8]};
                    IDX_W'(3): frm.payload = OP_MOV_HIGH;
                    IDX_W'(4): frm.payload = {OP_LOAD_LIT, ptr[7:0]};
                    default:   frm.payload = OP_MOV_LOW;
                endcase
            end
            PH_ERASE: begin
                case (idx)
                    IDX_W'(0): frm.payload = OP_SET_WREN;
                    IDX_W'(1): frm.payload = OP_SET_FREE;
                    default:   frm.payload = OP_SET_WR;
                endcase
            end
            PH_EHOLD: frm.hold_erase = 1'b1;
            PH_WRITE: begin
                frm.cmd     = (idx == IDX_W'(WORDS - 1)) ? CMD_WR_START : CMD_WR_INC;
                frm.payload = wdata;
            end
            PH_PHOLD: frm.hold_prog = 1'b1;
            PH_WDIS:  frm.payload = OP_CLR_WREN;
            default:  ;
        endcase
    end

endmodule

// File: rtl/prs_shifter.sv
module prs_shifter
    import prs_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int ERASE_HOLD = 2000,
    parameter int PROG_HOLD  = 1000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frm_valid,
    input  frame_t frm,
    output logic   frm_ready,
    output logic   pgc,
    output logic   pgd
);
    localparam int FRAME_BITS = 20;
    localparam int HOLD_BIT   = 3;
    localparam int MAX_A      = (ERASE_HOLD > PROG_HOLD) ? ERASE_HOLD : PROG_HOLD;
    localparam int MAX_CNT    = (MAX_A > HALF_DIV) ? MAX_A : HALF_DIV;
    localparam int CW         = $clog2(MAX_CNT + 1);
    localparam int BITW       = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {SH_IDLE, SH_HIGH, SH_LOW} sh_e;

    typedef struct packed {
        sh_e                   st;
        logic [CW-1:0]         cnt;
        logic [BITW-1:0]       bitn;
        logic [FRAME_BITS-1:0] shreg;
        logic                  he;
        logic                  hp;
        logic                  pgc;
        logic                  pgd;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        frm_ready = (q.st == SH_IDLE);
        case (q.st)
            SH_IDLE: begin
                if (frm_valid) begin
                    d.shreg = {frm.payload, frm.cmd};
                    d.he    = frm.hold_erase;
                    d.hp    = frm.hold_prog;
                    d.bitn  = '0;
                    d.pgd   = frm.cmd[0];
                    d.pgc   = 1'b1;
                    d.cnt   = CW'(HALF_DIV - 1);
                    d.st    = SH_HIGH;
                end
            end
            SH_HIGH: begin
                if (q.cnt == '0) begin
                    d.pgc = 1'b0;
                    d.cnt = CW'(HALF_DIV - 1);
                    d.st  = SH_LOW;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SH_LOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.bitn == BITW'(FRAME_BITS - 1)) begin
                    d.st  = SH_IDLE;
                    d.pgd = 1'b0;
                end else begin
                    d.bitn  = q.bitn + 1'b1;
                    d.shreg = q.shreg >> 1;
                    d.pgd   = q.shreg[1];
                    d.pgc   = 1'b1;
                    d.st    = SH_HIGH;
                    if (q.bitn == BITW'(HOLD_BIT - 1) && q.he) begin
                        d.cnt = CW'(ERASE_HOLD - 1);
                    end else if (q.bitn == BITW'(HOLD_BIT - 1) && q.hp) begin
                        d.cnt = CW'(PROG_HOLD - 1);
                    end else begin
                        d.cnt = CW'(HALF_DIV - 1);
                    end
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign pgc = q.pgc;
    assign pgd = q.pgd;

    // R2
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgc && $past(pgc)) |-> $stable(pgd));

    // R4
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_HIGH && q.bitn == BITW'(HOLD_BIT) && (q.he || q.hp)) |-> !pgd);

    // R1
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> !pgc);

endmodule

// File: rtl/page_rewrite_seq.sv
module page_rewrite_seq
    import prs_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int ERASE_HOLD = 2000,
    parameter int PROG_HOLD  = 1000,
    parameter int WORDS      = 32,
    parameter int BURSTS     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [21:0] page_addr,
    output logic        rd_req,
    input  logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        pgc,
    output logic        pgd
);
    localparam int PTR_FRAMES   = 6;
    localparam int ERASE_FRAMES = 3;
    localparam int PAGE_BYTES   = 2 * WORDS * BURSTS;
    localparam int ALIGN_W      = $clog2(PAGE_BYTES);
    localparam int IDX_W        = $clog2((WORDS > PTR_FRAMES) ? WORDS : PTR_FRAMES);
    localparam int BW           = (BURSTS > 1) ? $clog2(BURSTS) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic [BW-1:0]    burst;
        logic [21:0]      page;
        logic             done;
        logic             err;
    } seq_t;

    seq_t   q, d;
    frame_t frm;
    logic   frm_valid;
    logic   frm_ready;
    logic   accept;

    prs_frame_gen #(
        .WORDS (WORDS),
        .BURSTS(BURSTS),
        .IDX_W (IDX_W),
        .BW    (BW)
    ) gen_i (
        .ph   (q.ph),
        .idx  (q.idx),
        .burst(q.burst),
        .page (q.page),
        .wdata(rd_data),
        .frm  (frm)
    );

    prs_shifter #(
        .HALF_DIV  (HALF_DIV),
        .ERASE_HOLD(ERASE_HOLD),
        .PROG_HOLD (PROG_HOLD)
    ) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_valid(frm_valid),
        .frm      (frm),
        .frm_ready(frm_ready),
        .pgc      (pgc),
        .pgd      (pgd)
    );

    assign frm_valid = (q.ph != PH_IDLE) && (q.ph != PH_DRAIN);
    assign accept    = frm_valid && frm_ready;
    assign rd_req    = accept && (q.ph == PH_WRITE);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (|page_addr[ALIGN_W-1:0]) begin
                        d.err = 1'b1;
                    end else begin
                        d.err   = 1'b0;
                        d.page  = page_addr;
                        d.idx   = '0;
                        d.burst = '0;
                        d.ph    = PH_PTR;
                    end
                end
            end
            PH_PTR: begin
                if (accept) begin
                    if (q.idx == IDX_W'(PTR_FRAMES - 1)) begin
                        d.idx = '0;
                        d.ph  = PH_ERASE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_ERASE: begin
                if (accept) begin
                    if (q.idx == IDX_W'(ERASE_FRAMES - 1)) begin
                        d.idx = '0;
                        d.ph  = PH_EHOLD;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_EHOLD: begin
                if (accept) begin
                    d.idx = '0;
                    d.ph  = PH_BPTR;
                end
            end
            PH_BPTR: begin
                if (accept) begin
                    if (q.idx == IDX_W'(PTR_FRAMES - 1)) begin
                        d.idx = '0;
                        d.ph  = PH_WRITE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_WRITE: begin
                if (accept) begin
                    if (q.idx == IDX_W'(WORDS - 1)) begin
                        d.idx = '0;
                        d.ph  = PH_PHOLD;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_PHOLD: begin
                if (accept) begin
                    if (q.burst == BW'(BURSTS - 1)) begin
                        d.ph = PH_WDIS;
                    end else begin
                        d.burst = q.burst + 1'b1;
                        d.idx   = '0;
                        d.ph    = PH_BPTR;
                    end
                end
            end
            PH_WDIS: begin
                if (accept) d.ph = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (frm_ready) begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.ph != PH_IDLE);
    assign done = q.done;
    assign err  = q.err;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !busy) |-> !pgc);

    // R11
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.page));

endmodule

// File: tb/page_rewrite_seq_tb.sv
module page_rewrite_seq_tb_top;
    localparam int HALF   = 1;
    localparam int EHOLD  = 37;
    localparam int PHOLD  = 23;
    localparam int WORDS  = 32;
    localparam int BURSTS = 16;
    localparam int NFR    = 6 + 3 + 1 + BURSTS * (6 + WORDS + 1) + 1;
    localparam int NCAP   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [21:0] page_addr = '0;
    logic        rd_req, busy, done, err, pgc, pgd;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    page_rewrite_seq #(
        .HALF_DIV(HALF), .ERASE_HOLD(EHOLD), .PROG_HOLD(PHOLD),
        .WORDS(WORDS), .BURSTS(BURSTS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
        .rd_req(rd_req), .rd_data(rd_data), .busy(busy), .done(done),
        .err(err), .pgc(pgc), .pgd(pgd)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [15:0] mem [0:511];
    int          req_total = 0;
    int          req_base  = 0;
    assign rd_data = mem[(req_total - req_base) & 511];

    logic [3:0]  cap_cmd [0:NCAP-1];
    logic [15:0] cap_pay [0:NCAP-1];
    int          cap_h4  [0:NCAP-1];
    int          cap_n = 0;
    int          bad_high = 0;
    int          glitch = 0;
    int          hi_total = 0;

    logic [3:0]  exp_cmd [0:NFR-1];
    logic [15:0] exp_pay [0:NFR-1];
    int          exp_h4  [0:NFR-1];
    string       exp_tag [0:NFR-1];

    logic        pgc_prev = 0, pgd_prev = 0, req_prev = 0, bitv = 0;
    logic [19:0] shf = '0;
    int          nbit = 0, hi_len = 0, h4 = 0;

    always @(negedge clk) begin
        if (pgc) begin
            hi_len++;
            hi_total++;
            if (pgc_prev && pgd != pgd_prev) glitch++;
            bitv = pgd;
        end else if (pgc_prev) begin
            shf = {bitv, shf[19:1]};
            nbit++;
            if (nbit == 4) h4 = hi_len;
            else if (hi_len != HALF) bad_high++;
            hi_len = 0;
            if (nbit == 20) begin
                if (cap_n < NCAP) begin
                    cap_cmd[cap_n] = shf[3:0];
                    cap_pay[cap_n] = shf[19:4];
                    cap_h4[cap_n]  = h4;
                end
                cap_n++;
                nbit = 0;
            end
        end
        if (req_prev) req_total++;
        req_prev = rd_req;
        pgc_prev = pgc;
        pgd_prev = pgd;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void put(input int i, input logic [3:0] c,
                                input logic [15:0] p, input int h, input string t);
        exp_cmd[i] = c;
        exp_pay[i] = p;
        exp_h4[i]  = h;
        exp_tag[i] = t;
    endfunction

    function automatic int put_ptr(input int i, input logic [21:0] a, input string t);
        put(i,     4'h0, {8'h0E, 2'b00, a[21:16]}, HALF, t);
        put(i + 1, 4'h0, 16'h6EF8, HALF, t);
        put(i + 2, 4'h0, {8'h0E, a[15:8]}, HALF, t);
        put(i + 3, 4'h0, 16'h6EF7, HALF, t);
        put(i + 4, 4'h0, {8'h0E, a[7:0]}, HALF, t);
        put(i + 5, 4'h0, 16'h6EF6, HALF, t);
        return i + 6;
    endfunction

    function automatic void build(input logic [21:0] a);
        int i = 0;
        i = put_ptr(i, a, "R3");
        put(i, 4'h0, 16'h84A6, HALF, "R4"); i++;
        put(i, 4'h0, 16'h88A6, HALF, "R4"); i++;
        put(i, 4'h0, 16'h82A6, HALF, "R4"); i++;
        put(i, 4'h0, 16'h0000, EHOLD, "R4"); i++;
        for (int b = 0; b < BURSTS; b++) begin
            i = put_ptr(i, a + 22'(b * 2 * WORDS), "R5");
            for (int w = 0; w < WORDS; w++) begin
                put(i, (w == WORDS - 1) ? 4'hF : 4'hD, mem[b * WORDS + w], HALF, "R5");
                i++;
            end
            put(i, 4'h0, 16'h0000, PHOLD, "R6"); i++;
        end
        put(i, 4'h0, 16'h94A6, HALF, "R7");
    endfunction

    task automatic run_page(input logic [21:0] a, input int pat, input bit poke);
        int base, bh0, gl0, cyc, nbusy;
        for (int k = 0; k < 512; k++) begin
            case (pat)
                0:       mem[k] = 16'($urandom);
                1:       mem[k] = k[0] ? 16'h0000 : 16'hFFFF;
                default: mem[k] = 16'(k * 3 + 1);
            endcase
        end
        build(a);
        base = cap_n;
        bh0  = bad_high;
        gl0  = glitch;
        req_base = req_total;
        @(negedge clk);
        start = 1'b1;
        page_addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        chk(err == 1'b0, "R10", "err cleared by good start", err, 0);
        cyc = 0;
        nbusy = 0;
        while (!done && cyc < 40000) begin
            if (poke && cyc == 700) begin
                start = 1'b1;
                page_addr = a ^ 22'h000400;
            end else begin
                start = 1'b0;
            end
            if (!busy) nbusy++;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R9", "done seen", done, 1);
        chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
        chk(nbusy == 0, "R9", "busy gaps during run", nbusy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done single cycle", done, 0);
        chk(cap_n - base == NFR, "R7", "frame count", cap_n - base, NFR);
        chk(req_total - req_base == BURSTS * WORDS, "R8", "word requests",
            req_total - req_base, BURSTS * WORDS);
        chk(bad_high == bh0, "R2", "ordinary high phase length", bad_high - bh0, 0);
        chk(glitch == gl0, "R2", "data change during clock high", glitch - gl0, 0);
        for (int f = 0; f < NFR; f++) begin
            chk(cap_cmd[base + f] == exp_cmd[f] && cap_pay[base + f] == exp_pay[f]
                && cap_h4[base + f] == exp_h4[f], exp_tag[f],
                $sformatf("frame %0d (%s)", f, poke ? "R11 busy start" : "cmd/payload/hold4"),
                {24'(cap_h4[base + f]), cap_cmd[base + f], cap_pay[base + f]},
                {24'(exp_h4[f]), exp_cmd[f], exp_pay[f]});
        end
    endtask

    task automatic bad_start(input logic [21:0] a);
        int c0, h0, r0;
        c0 = cap_n;
        h0 = hi_total;
        r0 = req_total;
        @(negedge clk);
        start = 1'b1;
        page_addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R10", "err on misaligned start", err, 1);
        chk(busy == 1'b0, "R10", "busy stays low", busy, 0);
        repeat (300) @(negedge clk);
        chk(hi_total == h0 && cap_n == c0, "R10", "no serial clocks", hi_total - h0, 0);
        chk(req_total == r0, "R10", "no word requests", req_total - r0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pgc, pgd, busy, done, err, rd_req} == 6'b0, "R1", "reset outputs",
            {pgc, pgd, busy, done, err, rd_req}, 0);
        run_page({6'($urandom), 6'($urandom), 10'h000}, 0, 1'b1);
        bad_start(22'h012A01);
        bad_start(22'h000200);
        run_page(22'h3FFC00, 1, 1'b0);
        run_page(22'h000000, 2, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule